// File: doc/BRIEF.md
# Segment Table Lookup Scanner

This block turns the segment part of a 64-bit effective address into a 50-bit virtual segment identifier. It holds a parameterised table of segment entries. Each entry is stored as a 64-bit first word and a 32-bit second word. The first word carries a valid flag, a segment-size code and the stored effective segment number. The two words together carry the segment identifier and an 8-bit attribute byte.

A lookup starts with a one-cycle strobe. The block then walks the table one entry per cycle, starting at index 0, and stops at the first eligible entry whose masked segment number equals the masked address. It reports a hit with the spliced identifier, the in-segment offset mask and the attributes. If no entry matches, it reports a distinct miss result.

Entries are loaded through one write port, which has two modes. The segment-register mode packs a register-style source value into an entry. The raw mode stores both words as given. A read port returns the register-style view of any entry. Writes are accepted only while no scan is running.

Top module: `seg_xlate_scan`

## Requirements
- R1: After reset `lk_busy` and `lk_done` are 0, `wr_ready` is 1, every entry reads back as 0 and a lookup misses.
- R2: A `lk_start` sampled while idle starts a scan, and `lk_busy` is 1 from the next cycle until the result cycle. A `lk_start` sampled while busy is ignored and does not change the result or its timing.
- R3: The scan examines entry i in the i-th cycle after the start edge and stops at the first match, so a match at index i gives `lk_done` i+1 cycles after the start edge. When several entries match, the lowest index wins.
- R4: An entry is eligible only when bit 27 of its first word is 1 and bits 26:25 are 00 (256 MB segment). Any other entry is skipped.
- R5: An entry matches when effective-address bits 63:28 equal first-word bits 63:28. On a hit `lk_pmask` is 64'h0000_0000_0FFF_FFFF.
- R6: On a hit, `lk_vsid` = {first word[25:0], second word[31:8]} and `lk_attr` = second word[7:0].
- R7: When no eligible entry matches, `lk_done` rises N_ENT cycles after the start edge with `lk_hit`=0, and `lk_vsid`, `lk_pmask` and `lk_attr` are all 0.
- R8: A write with `wr_raw`=0 to index n stores first word = (n<<28) | (1<<27) | wr_data[26:24] and second word = (wr_data[23:0]<<8) | (wr_data[30:27]<<4). Bits 63:31 of wr_data are ignored.
- R9: A write with `wr_raw`=1 stores `wr_data` as the first word and `wr_aux` as the second word.
- R10: `rd_data` for entry `rd_idx` is 0 when bit 27 of its first word is 0. Otherwise it is second word[7:4] at bits 30:27, first word[2:0] at bits 26:24 and second word[31:8] at bits 23:0, with all other bits 0. It is combinational.
- R11: `wr_ready` is 0 while busy. A `wr_en` sampled while `wr_ready` is 0 leaves the table unchanged.
- R12: `lk_done` is a one-cycle pulse. `lk_hit`, `lk_vsid`, `lk_pmask` and `lk_attr` keep their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_start | input | 1 | Lookup start strobe |
| lk_ea | input | 64 | Effective address to translate |
| lk_busy | output | 1 | Scan in progress |
| lk_done | output | 1 | One-cycle result pulse |
| lk_hit | output | 1 | 1 = segment found, 0 = not found |
| lk_vsid | output | 50 | Virtual segment identifier |
| lk_pmask | output | 64 | In-segment offset mask |
| lk_attr | output | 8 | Attribute byte of the matching entry |
| wr_en | input | 1 | Entry write request |
| wr_ready | output | 1 | Write accepted this cycle when 1 |
| wr_raw | input | 1 | 1 = raw two-word write, 0 = register-style write |
| wr_idx | input | 5 | Entry index to write |
| wr_data | input | 64 | Register-style source, or raw first word |
| wr_aux | input | 32 | Raw second word |
| rd_idx | input | 5 | Entry index to read |
| rd_data | output | 64 | Register-style view of the entry |

## Verification
A wrong scan index or a wrong early stop shows up as `lk_done` arriving in the wrong cycle, so the bench measures latency against the index of the expected match. A corrupted entry field shows up on `rd_data` in the same cycle and on the next hit result. An eligibility decode error turns into a hit on a skipped entry, or into a miss that ends after N_ENT cycles. A write that leaks through during a scan changes the register-style readback right after that scan.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int EA_W     = 64;
  localparam int W1_W     = 32;
  localparam int VSID_W   = 50;
  localparam int ATTR_W   = 8;
  localparam int VLD_BIT  = 27;
  localparam int SZ_HI    = 26;
  localparam int SZ_LO    = 25;
  localparam int ESID_LSB = 28;
  localparam logic [1:0] SZ_256M = 2'b00;

  typedef struct packed {
    logic [EA_W-1:0] w0;
    logic [W1_W-1:0] w1;
  } seg_ent_t;

  // Compare mask for a size code; codes other than 256 MB compare nothing.
  function automatic logic [EA_W-1:0] seg_cmp_mask(input logic [1:0] sz);
    logic [EA_W-1:0] m;
    m = '0;
    if (sz == SZ_256M) m = {{(EA_W-ESID_LSB){1'b1}}, {ESID_LSB{1'b0}}};
    return m;
  endfunction
endpackage

// File: rtl/seg_ent_store.sv
module seg_ent_store
  import seg_xlate_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IW    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            wr_raw,
  input  logic [IW-1:0]   wr_idx,
  input  logic [EA_W-1:0] wr_data,
  input  logic [W1_W-1:0] wr_aux,
  input  logic [IW-1:0]   scan_idx,
  output seg_ent_t        scan_ent,
  input  logic [IW-1:0]   rd_idx,
  output seg_ent_t        rd_ent
);
  seg_ent_t ent_q [N_ENT];
  seg_ent_t wr_ent;

  // Register-style packing or raw pass-through
  always_comb begin
    wr_ent = '0;
    if (wr_raw) begin
      wr_ent.w0 = wr_data;
      wr_ent.w1 = wr_aux;
    end else begin
      wr_ent.w0[ESID_LSB +: IW] = wr_idx;
      wr_ent.w0[VLD_BIT]        = 1'b1;
      wr_ent.w0[2:0]            = wr_data[26:24];
      wr_ent.w1[31:8]           = wr_data[23:0];
      wr_ent.w1[7:4]            = wr_data[30:27];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++)
        if (we && (wr_idx == IW'(i))) ent_q[i] <= wr_ent;
    end
  end

  assign scan_ent = ent_q[scan_idx];
  assign rd_ent   = ent_q[rd_idx];
endmodule

// File: rtl/seg_ent_match.sv
module seg_ent_match
  import seg_xlate_pkg::*;
(
  input  seg_ent_t            ent,
  input  logic [EA_W-1:0]     ea,
  output logic                hit,
  output logic [EA_W-1:0]     cmp_mask,
  output logic [VSID_W-1:0]   vsid,
  output logic [ATTR_W-1:0]   attr
);
  logic elig;

  assign elig     = ent.w0[VLD_BIT] && (ent.w0[SZ_HI:SZ_LO] == SZ_256M);
  assign cmp_mask = seg_cmp_mask(ent.w0[SZ_HI:SZ_LO]);
  assign hit      = elig && ((ea & cmp_mask) == (ent.w0 & cmp_mask));
  // identifier spliced from the two storage words
  assign vsid     = {ent.w0[25:0], ent.w1[31:8]};
  assign attr     = ent.w1[ATTR_W-1:0];
endmodule

// File: rtl/seg_scan_ctl.sv
module seg_scan_ctl
  import seg_xlate_pkg::*;
#(
  parameter int N_ENT = 32,
  parameter int IW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EA_W-1:0]   ea_in,
  input  logic              m_hit,
  input  logic [EA_W-1:0]   m_cmp,
  input  logic [VSID_W-1:0] m_vsid,
  input  logic [ATTR_W-1:0] m_attr,
  output logic [EA_W-1:0]   ea_q,
  output logic [IW-1:0]     idx_q,
  output logic              busy_q,
  output logic              done_q,
  output logic              hit_q,
  output logic [VSID_W-1:0] vsid_q,
  output logic [EA_W-1:0]   pm_q,
  output logic [ATTR_W-1:0] attr_q
);
  localparam logic [IW-1:0] LAST = IW'(N_ENT - 1);

  logic              busy_d, done_d, hit_d;
  logic [IW-1:0]     idx_d;
  logic [EA_W-1:0]   ea_d, pm_d;
  logic [VSID_W-1:0] vsid_d;
  logic [ATTR_W-1:0] attr_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    ea_d   = ea_q;
    done_d = 1'b0;
    hit_d  = hit_q;
    vsid_d = vsid_q;
    pm_d   = pm_q;
    attr_d = attr_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        ea_d   = ea_in;
      end
    end else if (m_hit) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      hit_d  = 1'b1;
      vsid_d = m_vsid;
      pm_d   = ~m_cmp;
      attr_d = m_attr;
    end else if (idx_q == LAST) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      hit_d  = 1'b0;
      vsid_d = '0;
      pm_d   = '0;
      attr_d = '0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      ea_q   <= '0;
      hit_q  <= 1'b0;
      vsid_q <= '0;
      pm_q   <= '0;
      attr_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
      ea_q   <= ea_d;
      hit_q  <= hit_d;
      vsid_q <= vsid_d;
      pm_q   <= pm_d;
      attr_q <= attr_d;
    end
  end
endmodule

// File: rtl/seg_xlate_scan.sv
module seg_xlate_scan
  import seg_xlate_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_start,
  input  logic [EA_W-1:0]   lk_ea,
  output logic              lk_busy,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [VSID_W-1:0] lk_vsid,
  output logic [EA_W-1:0]   lk_pmask,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic              wr_en,
  output logic              wr_ready,
  input  logic              wr_raw,
  input  logic [IW-1:0]     wr_idx,
  input  logic [EA_W-1:0]   wr_data,
  input  logic [W1_W-1:0]   wr_aux,
  input  logic [IW-1:0]     rd_idx,
  output logic [EA_W-1:0]   rd_data
);
  seg_ent_t          scan_ent, rd_ent;
  logic [IW-1:0]     scan_idx;
  logic [EA_W-1:0]   ea_q, m_cmp;
  logic              m_hit;
  logic [VSID_W-1:0] m_vsid;
  logic [ATTR_W-1:0] m_attr;
  logic              unused_rd;

  // writes are held off for the whole scan
  assign wr_ready = ~lk_busy;

  seg_ent_store #(.N_ENT(N_ENT), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en & wr_ready), .wr_raw(wr_raw),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_aux(wr_aux),
    .scan_idx(scan_idx), .scan_ent(scan_ent), .rd_idx(rd_idx), .rd_ent(rd_ent)
  );

  seg_ent_match u_match (
    .ent(scan_ent), .ea(ea_q), .hit(m_hit), .cmp_mask(m_cmp),
    .vsid(m_vsid), .attr(m_attr)
  );

  seg_scan_ctl #(.N_ENT(N_ENT), .IW(IW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(lk_start), .ea_in(lk_ea),
    .m_hit(m_hit & lk_busy), .m_cmp(m_cmp), .m_vsid(m_vsid), .m_attr(m_attr),
    .ea_q(ea_q), .idx_q(scan_idx), .busy_q(lk_busy), .done_q(lk_done),
    .hit_q(lk_hit), .vsid_q(lk_vsid), .pm_q(lk_pmask), .attr_q(lk_attr)
  );

  // register-style view of an entry
  always_comb begin
    rd_data = '0;
    if (rd_ent.w0[VLD_BIT]) begin
      rd_data[30:27] = rd_ent.w1[7:4];
      rd_data[26:24] = rd_ent.w0[2:0];
      rd_data[23:0]  = rd_ent.w1[31:8];
    end
  end

  assign unused_rd = ^{rd_ent.w0[EA_W-1:VLD_BIT+1], rd_ent.w0[VLD_BIT-1:3], rd_ent.w1[3:0]};
endmodule

// File: rtl/seg_xlate_scan_chk.sv
module seg_xlate_scan_chk #(
  parameter int N_ENT = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_start,
  input logic        lk_busy,
  input logic        lk_done,
  input logic        lk_hit,
  input logic [49:0] lk_vsid,
  input logic [63:0] lk_pmask,
  input logic [7:0]  lk_attr
);
  int unsigned scan_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_cnt <= 0;
    else if (lk_start && !lk_busy) scan_cnt <= 0;
    else if (lk_busy) scan_cnt <= scan_cnt + 1;
  end

  assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_start && !lk_busy) |=> lk_busy);
  assert_done_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> !lk_busy);
  assert_scan_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_busy |-> (scan_cnt < N_ENT));
  assert_hit_pmask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_hit) |-> (lk_pmask == 64'h0000_0000_0FFF_FFFF));
  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_vsid == '0 && lk_pmask == '0 && lk_attr == '0));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |=> !lk_done);
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_done |-> ($stable(lk_hit) && $stable(lk_vsid) && $stable(lk_attr)));
endmodule

bind seg_xlate_scan seg_xlate_scan_chk #(.N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_busy(lk_busy),
  .lk_done(lk_done), .lk_hit(lk_hit), .lk_vsid(lk_vsid),
  .lk_pmask(lk_pmask), .lk_attr(lk_attr)
);

// File: tb/seg_xlate_scan_tb.sv
module seg_xlate_scan_tb_top;
  localparam int N  = 32;
  localparam int IW = 5;

  logic        clk, rst_n;
  logic        lk_start, lk_busy, lk_done, lk_hit;
  logic [63:0] lk_ea, lk_pmask;
  logic [49:0] lk_vsid;
  logic [7:0]  lk_attr;
  logic        wr_en, wr_ready, wr_raw;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [63:0] wr_data, rd_data;
  logic [31:0] wr_aux;

  int n_chk = 0, n_fail = 0;

  seg_xlate_scan #(.N_ENT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_start(lk_start), .lk_ea(lk_ea),
    .lk_busy(lk_busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_vsid(lk_vsid),
    .lk_pmask(lk_pmask), .lk_attr(lk_attr), .wr_en(wr_en), .wr_ready(wr_ready),
    .wr_raw(wr_raw), .wr_idx(wr_idx), .wr_data(wr_data), .wr_aux(wr_aux),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] mw0 [N];
  logic [31:0] mw1 [N];
  logic        m_busy, m_done, m_hit, p_hit;
  logic [49:0] m_vsid, p_vsid;
  logic [7:0]  m_attr, p_attr;
  int          m_left;

  function automatic logic [63:0] exp_rd(input int i);
    if (!mw0[i][27]) return 64'd0;
    return {33'd0, mw1[i][7:4], mw0[i][2:0], mw1[i][31:8]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_hit = 0; m_vsid = 0; m_attr = 0; m_left = 0;
      for (int i = 0; i < N; i++) begin mw0[i] = 0; mw1[i] = 0; end
    end else begin
      automatic logic was_busy = m_busy;
      m_done = 0;
      if (was_busy) begin
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_hit = p_hit; m_vsid = p_vsid; m_attr = p_attr;
        end else m_left--;
      end
      if (!was_busy && wr_en) begin
        if (wr_raw) begin mw0[wr_idx] = wr_data; mw1[wr_idx] = wr_aux; end
        else begin
          mw0[wr_idx] = (64'(wr_idx) << 28) | (64'd1 << 27) | ((wr_data >> 24) & 64'h7);
          mw1[wr_idx] = wr_data[23:0] * 256 + ((wr_data[31:0] >> 27) & 32'hF) * 16;
        end
      end
      if (!was_busy && lk_start) begin
        p_hit = 0; p_vsid = 0; p_attr = 0; m_left = N - 1;
        for (int i = N - 1; i >= 0; i--)
          if (mw0[i][27] && mw0[i][26:25] == 2'b00 && mw0[i][63:28] == lk_ea[63:28]) begin
            p_hit = 1; m_left = i;
            p_vsid = (50'(mw0[i]) << 24) | 50'(mw1[i] >> 8);
            p_attr = mw1[i][7:0];
          end
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "busy", 64'(lk_busy), 64'(m_busy));
      chk("R11", "wr_ready", 64'(wr_ready), 64'(!m_busy));
      chk("R12", "done", 64'(lk_done), 64'(m_done));
      chk("R3", "hit", 64'(lk_hit), 64'(m_hit));
      chk("R6", "vsid", 64'(lk_vsid), 64'(m_vsid));
      chk("R6", "attr", 64'(lk_attr), 64'(m_attr));
      chk("R5", "pmask", lk_pmask, m_hit ? 64'h0FFF_FFFF : 64'd0);
      chk("R10", "rd_data", rd_data, exp_rd(int'(rd_idx)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic raw, input int idx, input logic [63:0] d, input logic [31:0] a);
    wr_en = 1; wr_raw = raw; wr_idx = IW'(idx); wr_data = d; wr_aux = a;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input logic [63:0] ea, input int exp_cyc, input string req, input int mode);
    int cyc = 0;
    lk_ea = ea; lk_start = 1;
    @(negedge clk);
    lk_start = 0;
    while (cyc < 200) begin
      if (mode == 1 && cyc == 1) begin lk_start = 1; lk_ea = ea ^ 64'h1000_0000; end
      if (mode == 1 && cyc == 2) lk_start = 0;
      if (mode == 2 && cyc == 1) begin
        wr_en = 1; wr_raw = 1; wr_idx = 7; wr_data = 64'h0000_0000_0800_0001; wr_aux = 32'h1234_5678;
      end
      if (mode == 2 && cyc == 2) begin chk("R11", "wr_ready during scan", 64'(wr_ready), 64'd0); wr_en = 0; end
      @(negedge clk);
      cyc++;
      if (lk_done) break;
    end
    chk(req, "latency", 64'(cyc), 64'(exp_cyc));
  endtask

  initial begin
    rst_n = 0; lk_start = 0; lk_ea = 0; wr_en = 0; wr_raw = 0; wr_idx = 0;
    wr_data = 0; wr_aux = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 64'(lk_busy), 0);
    chk("R1", "done", 64'(lk_done), 0);
    chk("R1", "wr_ready", 64'(wr_ready), 1);
    rd_idx = 9; #1 chk("R1", "rd_data", rd_data, 0);
    lookup(64'h0, N, "R1", 0);
    chk("R1", "empty table miss", 64'(lk_hit), 0);

    // R8: register-style write, upper source bits ignored
    wr(0, 3, 64'hFFFF_0000_DABC_DEF1, 32'hFFFF_FFFF);
    rd_idx = 3; #1 chk("R8", "readback", rd_data, 64'h5ABC_DEF1);
    lookup(64'h0000_0000_3123_4567, 4, "R3", 0);
    chk("R6", "vsid", 64'(lk_vsid), 64'h2BC_DEF1);
    chk("R6", "attr", 64'(lk_attr), 64'hB0);
    chk("R5", "pmask", lk_pmask, 64'h0FFF_FFFF);

    // R4: invalid entry at 0, 1 TB size code at 1, both skipped
    wr(1, 0, 64'h0000_0000_3000_0000, 32'hAAAA_AAAA);
    wr(1, 1, 64'h0000_0000_3A00_0000, 32'hBBBB_BBBB);
    lookup(64'h0000_0000_3000_0000, 4, "R4", 0);
    chk("R4", "hit from index 3", 64'(lk_attr), 64'hB0);
    rd_idx = 0; #1 chk("R10", "invalid reads zero", rd_data, 0);

    // R9: raw write and its register view
    wr(1, 2, 64'hABCD_0000_3800_0123, 32'hDEAD_BEEF);
    rd_idx = 2; #1 chk("R9", "raw readback", rd_data, 64'h73DE_ADBE);
    lookup(64'hABCD_0000_3FFF_FFFF, 3, "R5", 0);
    chk("R6", "raw vsid", 64'(lk_vsid), 64'h1_23DE_ADBE);
    chk("R6", "raw attr", 64'(lk_attr), 64'hEF);
    // R5: segment bit 28 differs -> miss
    lookup(64'hABCD_0000_2FFF_FFFF, N, "R5", 0);
    chk("R7", "miss hit", 64'(lk_hit), 0);
    chk("R7", "miss vsid", 64'(lk_vsid), 0);
    chk("R7", "miss pmask", lk_pmask, 0);
    chk("R7", "miss attr", 64'(lk_attr), 0);

    // R3: two matches, lower index wins
    wr(1, 9, 64'h1111_0000_0800_0005, 32'h0000_0099);
    wr(1, 5, 64'h1111_0000_0800_0005, 32'h0000_0055);
    lookup(64'h1111_0000_0FFF_0000, 6, "R3", 0);
    chk("R3", "priority attr", 64'(lk_attr), 64'h55);
    // R2: second start during scan ignored
    lookup(64'h1111_0000_0FFF_0000, 6, "R2", 1);
    chk("R2", "first request kept", 64'(lk_attr), 64'h55);
    @(negedge clk);
    chk("R12", "done pulse ends", 64'(lk_done), 0);
    chk("R12", "result held", 64'(lk_attr), 64'h55);

    // R11: write during scan dropped
    lookup(64'hFFFF_FFFF_FFFF_FFFF, N, "R11", 2);
    rd_idx = 7; #1 chk("R11", "entry untouched", rd_data, 0);
    repeat (3) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule